// File: doc/BRIEF.md
# Economy-Mode Machine-Cycle Rate Controller

This block sets how many input clocks make up one processor machine cycle. Three rates are available. Full speed uses 4 clocks per machine cycle. The slow economy rate uses 64 clocks, and the crawl rate uses 1024 clocks. Each machine cycle is split into four equal states, C1 to C4. The block reports the current state and emits two single-clock enables. One marks each state step. The other marks the last clock of every machine cycle, which the core and its peripherals use as their advance strobe.

Software asks for a rate by writing a 2-bit code. A legal request is held as pending and takes effect at the next machine-cycle boundary. The slow and crawl rates can only be entered from full speed. A direct request between them is dropped.

When switchback is enabled, three kinds of activity force full speed on the next clock and cancel any pending request: a start-bit falling edge on the receive line while reception is on, a write to the transmit buffer, and an acknowledged external interrupt. While switchback is on and the serial unit reports busy, rate writes are dropped.

Rate FSM states are RATE_FULL, RATE_SLOW and RATE_CRAWL. Its transitions are:
- FULL→SLOW and FULL→CRAWL: at a boundary, taking the pending request.
- SLOW→FULL and CRAWL→FULL: at a boundary, taking the pending request, or at once on switchback or reset.
- Self-loops otherwise.

Top module: `econ_clk_ctrl`

## Requirements
- R1: Reset, asynchronous and active low, puts the rate at full speed (rate_sel 2'b00) and the state at C1 (phase 0), and clears any pending request.
- R2: The state advances C1→C2→C3→C4→C1 with phase codes 0,1,2,3. Each state lasts 1, 16 or 256 clocks at full, slow or crawl rate, so a machine cycle takes 4, 64 or 1024 clocks. state_tick is high on the last clock of each state. mc_tick is high only on the last clock of C4.
- R3: An accepted rate write changes rate_sel only at the first machine-cycle boundary after the write cycle. The new rate governs the next machine cycle.
- R4: Rate codes on div_code and rate_sel are 2'b00 for 4 clocks, 2'b01 for 64 clocks and 2'b10 for 1024 clocks. A write of 2'b11 is ignored.
- R5: A request for 2'b10 while the rate in force is 2'b01 is ignored, and so is a request for 2'b01 while 2'b10 is in force. The current rate is kept.
- R6: With swb_en and rx_en high, a falling edge on rxd makes rate_sel 2'b00 on the next clock. With rx_en low, the edge has no effect.
- R7: With swb_en high, tx_wr makes rate_sel 2'b00 on the next clock.
- R8: With swb_en high, irq_ack makes rate_sel 2'b00 on the next clock.
- R9: With swb_en low, rxd, tx_wr and irq_ack have no effect on the rate.
- R10: While swb_en and ser_busy are both high, rate writes are ignored. Once ser_busy is low, writes are accepted again.
- R11: A switchback event in the same cycle as a rate write wins, and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_code | input | 2 | Requested rate code |
| div_wr | input | 1 | Rate write strobe |
| swb_en | input | 1 | Switchback enable |
| rx_en | input | 1 | Serial reception enabled |
| rxd | input | 1 | Serial receive line |
| tx_wr | input | 1 | Transmit buffer write strobe |
| irq_ack | input | 1 | Acknowledged external interrupt |
| ser_busy | input | 1 | Serial transfer in progress |
| rate_sel | output | 2 | Rate in force |
| phase | output | 2 | Current state, 0..3 = C1..C4 |
| state_tick | output | 1 | Last clock of a state |
| mc_tick | output | 1 | Last clock of a machine cycle |

## Verification
The failure modes show up at the ports as follows:
- A wrong prescale count or phase register shows up within one machine cycle as a misplaced state_tick or mc_tick, or a wrong phase code.
- A pending request held too long, or applied too early, moves rate_sel at a clock that is not a boundary. At crawl rate this can take up to 1024 clocks to appear.
- A wrong legality or lockout decision leaves rate_sel on the wrong value after the next boundary.
- A broken switchback path leaves rate_sel non-zero one clock after the triggering event.

// File: rtl/econ_pkg.sv
package econ_pkg;
    typedef enum logic [1:0] {
        RATE_FULL  = 2'b00,
        RATE_SLOW  = 2'b01,
        RATE_CRAWL = 2'b10
    } rate_e;

    localparam logic [1:0] CODE_RSV = 2'b11;
endpackage

// File: rtl/econ_swb_detect.sv
module econ_swb_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic swb_en,
    input  logic rx_en,
    input  logic rxd,
    input  logic tx_wr,
    input  logic irq_ack,
    output logic fire
);
    logic rxd_q;
    logic start_edge;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rxd_q <= 1'b1;
        else        rxd_q <= rxd;
    end

    assign start_edge = rx_en & rxd_q & ~rxd;
    assign fire       = swb_en & (start_edge | tx_wr | irq_ack);
endmodule

// File: rtl/econ_prescaler.sv
module econ_prescaler
    import econ_pkg::*;
#(
    parameter int DIV_SLOW  = 64,
    parameter int DIV_CRAWL = 1024
) (
    input  logic       clk,
    input  logic       rst_n,
    input  rate_e      rate,
    input  logic       restart,
    output logic [1:0] phase,
    output logic       step,
    output logic       mc_end
);
    localparam int CNT_W = $clog2(DIV_CRAWL / 4);
    localparam logic [CNT_W-1:0] LIM_SLOW  = CNT_W'(DIV_SLOW / 4 - 1);
    localparam logic [CNT_W-1:0] LIM_CRAWL = CNT_W'(DIV_CRAWL / 4 - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim;
    logic [1:0]       phase_q;

    always_comb begin
        unique case (rate)
            RATE_SLOW:  lim = LIM_SLOW;
            RATE_CRAWL: lim = LIM_CRAWL;
            default:    lim = '0;
        endcase
    end

    assign step   = (cnt_q == lim);
    assign mc_end = step & (phase_q == 2'd3);
    assign phase  = phase_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            phase_q <= 2'd0;
        end else begin
            if (step || restart) cnt_q <= '0;
            else                 cnt_q <= cnt_q + 1'b1;
            if (step)            phase_q <= phase_q + 2'd1;
        end
    end
endmodule

// File: rtl/econ_rate_fsm.sv
module econ_rate_fsm
    import econ_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] div_code,
    input  logic       div_wr,
    input  logic       swb_en,
    input  logic       ser_busy,
    input  logic       fire,
    input  logic       mc_end,
    output rate_e      rate
);
    rate_e rate_q, rate_n;
    rate_e pend_q, pend_n;
    logic  pend_v_q, pend_v_n;
    rate_e req;
    logic  legal;
    logic  accept;

    always_comb begin
        unique case (div_code)
            2'b01:   req = RATE_SLOW;
            2'b10:   req = RATE_CRAWL;
            default: req = RATE_FULL;
        endcase
    end

    // Next-state: boundary transitions first, then switchback override
    always_comb begin
        rate_n   = rate_q;
        pend_n   = pend_q;
        pend_v_n = pend_v_q;
        unique case (rate_q)
            RATE_FULL: begin
                if (mc_end && pend_v_q) begin
                    rate_n   = pend_q;
                    pend_v_n = 1'b0;
                end
            end
            RATE_SLOW, RATE_CRAWL: begin
                if (mc_end && pend_v_q) begin
                    rate_n   = pend_q;
                    pend_v_n = 1'b0;
                end
            end
            default: rate_n = RATE_FULL;
        endcase
        legal  = (req == RATE_FULL) || (rate_n == RATE_FULL) || (req == rate_n);
        accept = div_wr && (div_code != CODE_RSV) && legal && !(swb_en && ser_busy);
        if (fire) begin
            rate_n   = RATE_FULL;
            pend_v_n = 1'b0;
        end else if (accept) begin
            pend_n   = req;
            pend_v_n = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rate_q   <= RATE_FULL;
            pend_q   <= RATE_FULL;
            pend_v_q <= 1'b0;
        end else begin
            rate_q   <= rate_n;
            pend_q   <= pend_n;
            pend_v_q <= pend_v_n;
        end
    end

    always_comb rate = rate_q;
endmodule

// File: rtl/econ_clk_ctrl.sv
module econ_clk_ctrl
    import econ_pkg::*;
#(
    parameter int DIV_SLOW  = 64,
    parameter int DIV_CRAWL = 1024
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] div_code,
    input  logic       div_wr,
    input  logic       swb_en,
    input  logic       rx_en,
    input  logic       rxd,
    input  logic       tx_wr,
    input  logic       irq_ack,
    input  logic       ser_busy,
    output logic [1:0] rate_sel,
    output logic [1:0] phase,
    output logic       state_tick,
    output logic       mc_tick
);
    logic  fire;
    logic  mc_end;
    rate_e rate;

    econ_swb_detect u_swb (
        .clk     (clk),
        .rst_n   (rst_n),
        .swb_en  (swb_en),
        .rx_en   (rx_en),
        .rxd     (rxd),
        .tx_wr   (tx_wr),
        .irq_ack (irq_ack),
        .fire    (fire)
    );

    econ_rate_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .div_code (div_code),
        .div_wr   (div_wr),
        .swb_en   (swb_en),
        .ser_busy (ser_busy),
        .fire     (fire),
        .mc_end   (mc_end),
        .rate     (rate)
    );

    econ_prescaler #(
        .DIV_SLOW  (DIV_SLOW),
        .DIV_CRAWL (DIV_CRAWL)
    ) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .rate    (rate),
        .restart (fire),
        .phase   (phase),
        .step    (state_tick),
        .mc_end  (mc_end)
    );

    assign rate_sel = rate;
    assign mc_tick  = mc_end;
endmodule

// File: rtl/econ_clk_ctrl_chk.sv
module econ_clk_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] div_code,
    input logic       div_wr,
    input logic       swb_en,
    input logic       rx_en,
    input logic       rxd,
    input logic       tx_wr,
    input logic       irq_ack,
    input logic       ser_busy,
    input logic [1:0] rate_sel,
    input logic [1:0] phase,
    input logic       state_tick,
    input logic       mc_tick
);
    p_reset_full_r1: assert property (@(posedge clk)
        !rst_n |=> rate_sel == 2'b00);

    p_tick_in_c4_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mc_tick |-> (phase == 2'd3) && state_tick);

    p_phase_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        state_tick |=> phase == $past(phase) + 2'd1);

    p_phase_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !state_tick |=> $stable(phase));

    p_boundary_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !mc_tick |=> $stable(rate_sel) || rate_sel == 2'b00);

    p_no_slow_to_crawl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rate_sel == 2'b01 |=> rate_sel != 2'b10);

    p_no_crawl_to_slow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rate_sel == 2'b10 |=> rate_sel != 2'b01);

    p_rx_switch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        swb_en && rx_en && $fell(rxd) |=> rate_sel == 2'b00);

    p_tx_switch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        swb_en && tx_wr |=> rate_sel == 2'b00);

    p_irq_switch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        swb_en && irq_ack |=> rate_sel == 2'b00);
endmodule

bind econ_clk_ctrl econ_clk_ctrl_chk u_chk (.*);

// File: tb/econ_clk_ctrl_bench.sv
module econ_clk_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] div_code = 2'b00;
    logic       div_wr = 1'b0;
    logic       swb_en = 1'b0;
    logic       rx_en = 1'b0;
    logic       rxd = 1'b1;
    logic       tx_wr = 1'b0;
    logic       irq_ack = 1'b0;
    logic       ser_busy = 1'b0;
    logic [1:0] rate_sel;
    logic [1:0] phase;
    logic       state_tick;
    logic       mc_tick;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    econ_clk_ctrl u_econ_clk_ctrl (.*);

    // Reference model built from the requirements
    int m_rate = 0, m_pend = 0, m_cnt = 0, m_ph = 0;
    bit m_pv = 0, m_rxq = 1;

    function automatic int lim_of(int r);
        return (r == 1) ? 15 : (r == 2) ? 255 : 0;
    endfunction

    function automatic bit allowed(int want, int now);
        return (want == 0) || (now == 0) || (want == now);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_rate <= 0; m_pend <= 0; m_pv <= 0; m_cnt <= 0; m_ph <= 0; m_rxq <= 1;
        end else begin
            bit fire, stp, bnd, ok;
            int after;
            fire  = swb_en && (tx_wr || irq_ack || (rx_en && m_rxq && !rxd));
            stp   = (m_cnt == lim_of(m_rate));
            bnd   = stp && (m_ph == 3);
            after = (bnd && m_pv) ? m_pend : m_rate;
            ok    = div_wr && (div_code != 2'b11) && !(swb_en && ser_busy)
                    && allowed(int'(div_code), after);
            m_rxq <= rxd;
            m_cnt <= (stp || fire) ? 0 : m_cnt + 1;
            if (stp) m_ph <= (m_ph + 1) % 4;
            if (fire) begin
                m_rate <= 0; m_pv <= 0;
            end else begin
                m_rate <= after;
                if (ok) begin
                    m_pend <= int'(div_code); m_pv <= 1;
                end else if (bnd) m_pv <= 0;
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Cycle-by-cycle comparison against the model (R2, R3)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R3 rate_sel vs model", int'(rate_sel), m_rate);
            chk("R2 phase vs model", int'(phase), m_ph);
            chk("R2 state_tick vs model", int'(state_tick), int'(m_cnt == lim_of(m_rate)));
            chk("R2 mc_tick vs model", int'(mc_tick),
                int'(m_cnt == lim_of(m_rate) && m_ph == 3));
        end
    end

    task automatic drv();
        @(negedge clk); #2;
    endtask

    task automatic wr(input logic [1:0] c);
        drv(); div_code = c; div_wr = 1'b1;
        drv(); div_wr = 1'b0;
    endtask

    task automatic wait_mc();
        @(negedge clk);
        while (!mc_tick) @(negedge clk);
    endtask

    task automatic mc_len(output int n);
        wait_mc();
        n = 0;
        do begin @(negedge clk); n++; end while (!mc_tick);
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        int n;
        void'($urandom(32'd20240917));
        repeat (3) @(negedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rate after reset", int'(rate_sel), 0);
        mc_len(n); chk("R2 full machine cycle length", n, 4);

        wr(2'b11); wait_mc(); wait_mc(); @(negedge clk);
        chk("R4 reserved code ignored", int'(rate_sel), 0);

        wr(2'b01); wait_mc();
        chk("R3 no change before boundary", int'(rate_sel), 0);
        @(negedge clk);
        chk("R3 R4 slow after boundary", int'(rate_sel), 1);
        mc_len(n); chk("R2 slow machine cycle length", n, 64);

        wr(2'b10); wait_mc(); wait_mc(); @(negedge clk);
        chk("R5 slow to crawl ignored", int'(rate_sel), 1);

        drv(); swb_en = 1'b1; tx_wr = 1'b1;
        @(negedge clk); chk("R7 transmit write switchback", int'(rate_sel), 0);
        #2 tx_wr = 1'b0;

        wr(2'b10); wait_mc(); @(negedge clk);
        chk("R3 R4 crawl after boundary", int'(rate_sel), 2);
        mc_len(n); chk("R2 crawl machine cycle length", n, 1024);

        wr(2'b01); wait_mc(); @(negedge clk);
        chk("R5 crawl to slow ignored", int'(rate_sel), 2);

        drv(); irq_ack = 1'b1;
        @(negedge clk); chk("R8 interrupt switchback", int'(rate_sel), 0);
        #2 irq_ack = 1'b0;

        drv(); swb_en = 1'b0;
        wr(2'b01); wait_mc(); @(negedge clk);
        drv(); tx_wr = 1'b1; irq_ack = 1'b1; rx_en = 1'b1; rxd = 1'b0;
        drv(); tx_wr = 1'b0; irq_ack = 1'b0; rxd = 1'b1;
        @(negedge clk); chk("R9 triggers ignored without switchback", int'(rate_sel), 1);

        drv(); swb_en = 1'b1; rx_en = 1'b0; rxd = 1'b0;
        @(negedge clk); chk("R6 edge ignored with reception off", int'(rate_sel), 1);
        #2 rxd = 1'b1; rx_en = 1'b1;
        drv(); rxd = 1'b0;
        @(negedge clk); chk("R6 start edge switchback", int'(rate_sel), 0);
        #2 rxd = 1'b1;

        drv(); ser_busy = 1'b1;
        wr(2'b01); wait_mc(); wait_mc(); @(negedge clk);
        chk("R10 write locked out while busy", int'(rate_sel), 0);
        drv(); ser_busy = 1'b0;
        wr(2'b01); wait_mc(); @(negedge clk);
        chk("R10 write accepted after busy", int'(rate_sel), 1);

        drv(); tx_wr = 1'b1;
        drv(); tx_wr = 1'b0;
        drv(); div_code = 2'b01; div_wr = 1'b1; tx_wr = 1'b1;
        drv(); div_wr = 1'b0; tx_wr = 1'b0;
        wait_mc(); wait_mc(); @(negedge clk);
        chk("R11 switchback beats write", int'(rate_sel), 0);

        wr(2'b01); wait_mc(); @(negedge clk);
        drv(); rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset rate", int'(rate_sel), 0);
        chk("R1 reset phase", int'(phase), 0);
        #2 rst_n = 1'b1;

        // Constrained random phase, checked by the model each cycle
        for (int i = 0; i < 60000; i++) begin
            drv();
            div_wr   = ($urandom % 300) == 0;
            div_code = 2'($urandom % 4);
            tx_wr    = ($urandom % 2500) == 0;
            irq_ack  = ($urandom % 2500) == 0;
            if (($urandom % 400) == 0)  rxd = ~rxd;
            if (($urandom % 1000) == 0) rx_en = ~rx_en;
            if (($urandom % 3000) == 0) swb_en = ~swb_en;
            if (($urandom % 800) == 0)  ser_busy = ~ser_busy;
        end
        drv(); div_wr = 1'b0; tx_wr = 1'b0; irq_ack = 1'b0;
        @(negedge clk);
        finish_run();
    end
endmodule